// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address presented to a synchronous burst SRAM array. A base address is captured from the external address bus whenever one of two active-low address strobes is asserted: a controller strobe, which loads regardless of chip enable, and a processor strobe, which loads only while chip enable is low. After a load, an active-low advance input steps a two-bit beat counter through a four-beat burst.

The counter only ever changes the two least significant address bits. A static order input selects how those bits are formed. Linear order adds the counter to the loaded low bits, modulo four. Interleaved order XORs the counter into the loaded low bits. The upper address bits stay at the loaded value for the whole burst.

At every load, the block also registers a chip-selected flag from chip enable and the two chip selects. The flag is held until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: A low controller strobe (`ctrl_strobe_n`) on a rising clock edge loads `addr_i` into the address register, whatever the value of `chip_en_n`.
- R2: A low processor strobe (`proc_strobe_n`) loads `addr_i` only when `chip_en_n` is also low. While `chip_en_n` is high, the processor strobe alone leaves `word_addr_o` and `selected_o` unchanged.
- R3: On a rising edge with no load and `advance_n` low, the beat counter increments. It wraps from 3 back to 0, so after four advances the address returns to its loaded value.
- R4: On a rising edge with no load and `advance_n` high, `word_addr_o` and `selected_o` keep their values.
- R5: When `interleave_i` is 0 (linear order), bits [1:0] of `word_addr_o` equal the loaded bits [1:0] plus the counter, modulo 4. Bits [AW-1:2] always equal the loaded upper bits, with no carry into them.
- R6: When `interleave_i` is 1 (interleaved order), bits [1:0] of `word_addr_o` equal the loaded bits [1:0] XOR the counter.
- R7: A load clears the beat counter to 0, so `word_addr_o` equals the loaded address on the next cycle. A load takes priority over an advance in the same cycle.
- R8: At each load, `selected_o` is set to 1 exactly when `chip_en_n` is 0, `cs_hi` is 1 and `cs_lo_n` is 0, and to 0 otherwise. Between loads it holds its value.
- R9: While `rst_n` is low, the address register, the counter and the selected flag are all 0, so both outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | External word address bus |
| proc_strobe_n | input | 1 | Processor address strobe, active low, gated by chip enable |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low, ungated |
| chip_en_n | input | 1 | Chip enable, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| advance_n | input | 1 | Burst advance, active low |
| interleave_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| word_addr_o | output | AW | Current word address |
| selected_o | output | 1 | Chip-selected flag captured at the last load |

## Verification
The assertions check the following on every cycle:
- a controller-strobe load is followed by the loaded address;
- a processor strobe blocked by chip enable leaves the upper address bits alone;
- a hold cycle keeps both outputs steady;
- a linear advance adds one to the low bits;
- each load captures the select decode.

Some behaviours can only be shown by the bench's scenarios, because they depend on the history of a whole burst:
- the XOR sequence of interleaved order;
- the wrap back to the base address after four beats;
- load priority when advance is asserted in the same cycle;
- the reset values.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
    // Two counter bits give a four-beat burst.
    localparam int unsigned BEAT_BITS = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/bsq_strobe_decode.sv
module bsq_strobe_decode (
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    input  logic chip_en_n,
    input  logic cs_hi,
    input  logic cs_lo_n,
    output logic load_o,
    output logic sel_o
);
    logic ctrl_req;
    logic proc_req;

    always_comb begin
        ctrl_req = ~ctrl_strobe_n;
        // The processor strobe only counts while chip enable is asserted.
        proc_req = ~proc_strobe_n & ~chip_en_n;
        load_o   = ctrl_req | proc_req;
        sel_o    = ~chip_en_n & cs_hi & ~cs_lo_n;
    end
endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
    parameter int unsigned CW = bsq_pkg::BEAT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          advance_i,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    localparam logic [CW-1:0] STEP = CW'(1);

    cnt_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            // A load restarts the burst and wins over an advance.
            state_d.cnt = '0;
        end else if (advance_i) begin
            // The counter wraps naturally at its width.
            state_d.cnt = state_q.cnt + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o = state_q.cnt;
endmodule

// File: rtl/bsq_low_bits.sv
module bsq_low_bits #(
    parameter int unsigned CW = bsq_pkg::BEAT_BITS
) (
    input  logic                  [CW-1:0] base_i,
    input  logic                  [CW-1:0] cnt_i,
    input  bsq_pkg::burst_order_e          order_i,
    output logic                  [CW-1:0] low_o
);
    logic [CW-1:0] lin_bits;
    logic [CW-1:0] xor_bits;

    // The linear order needs a carry chain; the interleaved order is bitwise.
    assign lin_bits = base_i + cnt_i;

    for (genvar b = 0; b < CW; b++) begin : g_xor
        assign xor_bits[b] = base_i[b] ^ cnt_i[b];
    end

    always_comb begin
        unique case (order_i)
            bsq_pkg::ORDER_XOR: low_o = xor_bits;
            default:            low_o = lin_bits;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int unsigned AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          chip_en_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          advance_n,
    input  logic          interleave_i,
    output logic [AW-1:0] word_addr_o,
    output logic          selected_o
);
    localparam int unsigned CW = bsq_pkg::BEAT_BITS;

    typedef struct packed {
        logic [AW-1:0] base;
        logic          sel;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic          load;
    logic          sel_now;
    logic [CW-1:0] beat;
    logic [CW-1:0] low_bits;
    bsq_pkg::burst_order_e order;

    assign order = bsq_pkg::burst_order_e'(interleave_i);

    bsq_strobe_decode i_decode (
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .chip_en_n     (chip_en_n),
        .cs_hi         (cs_hi),
        .cs_lo_n       (cs_lo_n),
        .load_o        (load),
        .sel_o         (sel_now)
    );

    bsq_beat_counter #(.CW(CW)) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .advance_i (~advance_n),
        .cnt_o     (beat)
    );

    bsq_low_bits #(.CW(CW)) i_low (
        .base_i  (state_q.base[CW-1:0]),
        .cnt_i   (beat),
        .order_i (order),
        .low_o   (low_bits)
    );

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.base = addr_i;
            state_d.sel  = sel_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_addr_o = {state_q.base[AW-1:CW], low_bits};
    assign selected_o  = state_q.sel;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          proc_strobe_n,
    input logic          ctrl_strobe_n,
    input logic          chip_en_n,
    input logic          cs_hi,
    input logic          cs_lo_n,
    input logic          advance_n,
    input logic          interleave_i,
    input logic [AW-1:0] word_addr_o,
    input logic          selected_o
);
    localparam int unsigned CW = bsq_pkg::BEAT_BITS;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic no_load;
    assign no_load = ctrl_strobe_n && (proc_strobe_n || chip_en_n);

    // R1, R7: a controller-strobe load appears unchanged on the next cycle.
    p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_strobe_n |=> word_addr_o == $past(addr_i));

    // R2: a processor strobe blocked by chip enable cannot touch the upper bits.
    p_proc_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_strobe_n && chip_en_n) |=> $stable(word_addr_o[AW-1:CW]));

    // R4: with no load and no advance, both outputs hold.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && advance_n) |=> ($stable(word_addr_o) && $stable(selected_o)));

    // R3, R5: a linear advance adds one to the low bits and leaves the upper bits alone.
    p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (no_load && !advance_n && !interleave_i && $stable(interleave_i)) |=>
        (word_addr_o[CW-1:0] == $past(word_addr_o[CW-1:0]) + ONE) &&
        $stable(word_addr_o[AW-1:CW]));

    // R8: each load captures the select decode.
    p_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !no_load |=> selected_o == $past(!chip_en_n && cs_hi && !cs_lo_n));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
    localparam int unsigned AW = 19;
    localparam realtime HALF = 2.5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_i;
    logic          proc_strobe_n, ctrl_strobe_n, chip_en_n, cs_hi, cs_lo_n;
    logic          advance_n, interleave_i;
    logic [AW-1:0] word_addr_o;
    logic          selected_o;

    int vectors = 0;
    int errors  = 0;

    // Reference model, built from the requirements.
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_sel;

    always #HALF clk = ~clk;

    burst_addr_seq #(.AW(AW)) i_burst_addr_seq (.*);

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] c, logic il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ c) : (b[1:0] + c);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic exp_load(logic ps, logic cs, logic ce);
        return !cs || (!ps && !ce);
    endfunction

    task automatic check(string req);
        logic [AW-1:0] ea;
        ea = exp_addr(m_base, m_cnt, interleave_i);
        vectors++;
        if (word_addr_o !== ea || selected_o !== m_sel) begin
            errors++;
            $display("FAIL %s: addr=%h sel=%b expected addr=%h sel=%b",
                     req, word_addr_o, selected_o, ea, m_sel);
        end
    endtask

    // Apply the inputs already driven, clock once, update the model, compare.
    task automatic step(string req);
        @(posedge clk);
        if (exp_load(proc_strobe_n, ctrl_strobe_n, chip_en_n)) begin
            m_base = addr_i;
            m_cnt  = 2'd0;
            m_sel  = !chip_en_n && cs_hi && !cs_lo_n;
        end else if (!advance_n) begin
            m_cnt = m_cnt + 2'd1;
        end
        #1;
        check(req);
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1;
        ctrl_strobe_n = 1'b1;
        advance_n     = 1'b1;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        addr_i = '1;
        chip_en_n = 1'b0;
        cs_hi = 1'b1;
        cs_lo_n = 1'b0;
        interleave_i = 1'b0;
        idle();
        ctrl_strobe_n = 1'b0;
        m_base = '0;
        m_cnt = '0;
        m_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset holds everything at zero, even with a strobe asserted.
        check("R9");
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        @(negedge clk);

        // R1: the controller strobe loads even while chip enable is high.
        chip_en_n = 1'b1;
        ctrl_strobe_n = 1'b0;
        addr_i = 19'h1_2347;
        step("R1");
        @(negedge clk);

        // R2: the processor strobe alone is blocked by a high chip enable.
        idle();
        proc_strobe_n = 1'b1;
        proc_strobe_n = 1'b0;
        addr_i = 19'h7_0000;
        step("R2");
        @(negedge clk);

        // R2: with chip enable low it loads, and R8 sees a full select.
        chip_en_n = 1'b0;
        addr_i = 19'h0_ABC3;
        step("R2");
        @(negedge clk);

        // R3, R5: a linear burst from low bits 3 wraps 3,0,1,2 and back to 3.
        idle();
        for (int i = 0; i < 4; i++) begin
            advance_n = 1'b0;
            step("R5");
            @(negedge clk);
        end

        // R4: advance high holds the address.
        idle();
        step("R4");
        @(negedge clk);

        // R6: interleaved burst from low bits 2 gives 2,3,0,1.
        interleave_i = 1'b1;
        ctrl_strobe_n = 1'b0;
        addr_i = 19'h5_5552;
        step("R6");
        @(negedge clk);
        idle();
        for (int i = 0; i < 4; i++) begin
            advance_n = 1'b0;
            step("R6");
            @(negedge clk);
        end

        // R7: a load in the same cycle as an advance wins and clears the counter.
        advance_n = 1'b0;
        step("R3");
        @(negedge clk);
        ctrl_strobe_n = 1'b0;
        addr_i = 19'h0_0011;
        step("R7");
        @(negedge clk);

        // R8: each failing select term gives an unselected load.
        idle();
        cs_hi = 1'b0;
        ctrl_strobe_n = 1'b0;
        step("R8");
        @(negedge clk);
        cs_hi = 1'b1;
        cs_lo_n = 1'b1;
        step("R8");
        @(negedge clk);
        cs_lo_n = 1'b0;
        chip_en_n = 1'b1;
        step("R8");
        @(negedge clk);
        idle();
        chip_en_n = 1'b0;
        step("R8");
        @(negedge clk);

        // Random stimulus; the burst order stays fixed within each segment.
        void'($urandom(32'd1234));
        for (int seg = 0; seg < 4; seg++) begin
            interleave_i = seg[0];
            ctrl_strobe_n = 1'b0;
            addr_i = AW'($urandom);
            step("R7");
            @(negedge clk);
            for (int i = 0; i < 1500; i++) begin
                addr_i        = AW'($urandom);
                ctrl_strobe_n = ($urandom_range(0, 7) != 0);
                proc_strobe_n = ($urandom_range(0, 5) != 0);
                chip_en_n     = $urandom_range(0, 1) == 1;
                cs_hi         = $urandom_range(0, 3) != 0;
                cs_lo_n       = $urandom_range(0, 3) == 0;
                advance_n     = $urandom_range(0, 2) == 0;
                step(interleave_i ? "R6" : "R5");
                @(negedge clk);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule